// File: doc/BRIEF.md
# I2C Clock-Stuck-High Timeout Monitor

This block observes the clock and data lines of an I2C bus. It raises a timeout when the clock line is held high for too long during a transfer. It keeps its own record of whether the bus is busy. That record is set by a START condition and cleared by a STOP condition, so it needs no busy input from the byte-level controller. A timeout counter runs on a prescaled tick only while four things are true: the bus is busy, the clock line is high, the timeout feature is enabled and the interface is enabled. If the counter passes the selected limit, the block sets a sticky timeout flag and an interrupt request in the same cycle.

Software chooses one of two limits with a single select bit. After a timeout, software recovers the interface by turning it off or by pulsing the interface reset. Either action clears the flag, the interrupt and the bus-busy record. The flag can also be cleared on its own, and the interrupt can be cleared on its own by an acknowledge.

Top module: `i2c_scl_timeout_mon`

## Requirements
- R1: After reset, `tmo_flag`, `irq_req` and `bus_busy` are 0.
- R2: `bus_busy` becomes 1 after SDA falls while SCL is high (START). It becomes 0 after SDA rises while SCL is high (STOP). Both lines pass through a two-stage synchronizer first.
- R3: The counter runs while `tmo_en`=1, `intf_en`=1, `bus_busy`=1 and SCL is high. It advances once per tick, and a tick is `PRESCALE` clocks. The timeout fires on tick N+1 of continuous SCL-high time, where N is `PERIOD_SHORT` when `tmo_sel`=0 and `PERIOD_LONG` when `tmo_sel`=1. On that event `tmo_flag` and `irq_req` both become 1 on the same clock edge. Measured from the clock edge that first samples `scl_in` high, the flag is visible after 1+(N+1)·PRESCALE further edges.
- R4: `tmo_sel` is captured when counting starts. Changing it while SCL is held high does not change the limit in use.
- R5: Each time SCL goes low, the high-time count returns to zero. High time is never added up across clock pulses.
- R6: While the bus is idle (`bus_busy`=0), no timeout fires, however long SCL stays high.
- R7: With `tmo_en`=0, no timeout fires.
- R8: `tmo_flag` stays at 1 until `tmo_flag_clr` is pulsed, or until recovery under R10. `irq_req` stays at 1 until `irq_ack` is pulsed, or until recovery under R10. Each clear affects only its own output.
- R9: After a timeout, the block does not fire again until the counter has been cleared, for example by SCL going low. This holds even if the flag is cleared while SCL is still high.
- R10: One cycle with `intf_rst`=1 or `intf_en`=0 clears `tmo_flag`, `irq_req`, `bus_busy` and the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw clock line level |
| sda_in | input | 1 | Raw data line level |
| tmo_en | input | 1 | Timeout detection enable |
| tmo_sel | input | 1 | Limit select: 0 short, 1 long |
| intf_en | input | 1 | Interface enable; 0 clears the monitor |
| intf_rst | input | 1 | Interface reset strobe |
| tmo_flag_clr | input | 1 | Software clear of the timeout flag |
| irq_ack | input | 1 | Interrupt accept / clear |
| tmo_flag | output | 1 | Sticky timeout flag |
| irq_req | output | 1 | Interrupt request |
| bus_busy | output | 1 | Bus busy between START and STOP |

## Verification
A wrong bus-busy record appears quickly in two ways. `bus_busy` differs from the expected value within a few cycles of a START or STOP. A timeout also fires while the bus is idle, or fails to fire during a transfer. A wrong counter or prescaler state moves the cycle on which the flag rises, so the bench measures that cycle exactly for both limit values. A stale select latch or a missing re-arm shows up within one timeout period. The flag then fires at the wrong limit, fires twice, or fires after short clock pulses.

// File: rtl/i2c_tmo_pkg.sv
package i2c_tmo_pkg;

   typedef struct packed {
      logic scl;
      logic sda;
   } i2c_lines_t;

   typedef enum logic {
      TMO_SHORT = 1'b0,
      TMO_LONG  = 1'b1
   } tmo_sel_e;

   function automatic int unsigned width_for(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/i2c_tmo_sync.sv
module i2c_tmo_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_tmo_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("i2c_tmo_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) chain[i] <= RST_VAL;
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/i2c_tmo_bus_state.sv
module i2c_tmo_bus_state (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic scl,
   input  logic sda,
   output logic busy
);

   logic scl_d, sda_d;
   logic start_cond, stop_cond;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl;
         sda_d <= sda;
      end
   end

   // Data edges only count while the clock line was and still is high.
   assign start_cond = scl & scl_d & sda_d & ~sda;
   assign stop_cond  = scl & scl_d & ~sda_d & sda;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          busy <= 1'b0;
      else if (clear)      busy <= 1'b0;
      else if (start_cond) busy <= 1'b1;
      else if (stop_cond)  busy <= 1'b0;
   end

endmodule

// File: rtl/i2c_tmo_counter.sv
module i2c_tmo_counter
   import i2c_tmo_pkg::*;
#(
   parameter int unsigned PRESCALE     = 64,
   parameter int unsigned PERIOD_SHORT = 256,
   parameter int unsigned PERIOD_LONG  = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic sel,
   output logic hit
);

   localparam int unsigned CW = width_for(PERIOD_LONG);
   localparam int unsigned PW = width_for(PRESCALE - 1);
   localparam logic [CW-1:0] LIM_SHORT = CW'(PERIOD_SHORT);
   localparam logic [CW-1:0] LIM_LONG  = CW'(PERIOD_LONG);

   if (PRESCALE < 1) begin : g_bad_prescale
      $error("i2c_tmo_counter: PRESCALE must be at least 1");
   end
   if (PERIOD_SHORT < 1) begin : g_bad_short
      $error("i2c_tmo_counter: PERIOD_SHORT must be at least 1");
   end
   if (PERIOD_LONG < PERIOD_SHORT) begin : g_bad_long
      $error("i2c_tmo_counter: PERIOD_LONG must not be below PERIOD_SHORT");
   end

   logic          tick;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] limit;
   tmo_sel_e      sel_q;
   logic          armed_q;

   // Tick generator: restarts from zero whenever counting is held.
   if (PRESCALE == 1) begin : g_no_prescale
      assign tick = run;
   end else begin : g_prescale
      localparam logic [PW-1:0] PS_LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] ps_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               ps_q <= '0;
         else if (!run)            ps_q <= '0;
         else if (ps_q == PS_LAST) ps_q <= '0;
         else                      ps_q <= ps_q + 1'b1;
      end
      assign tick = run & (ps_q == PS_LAST);
   end

   // Limit choice follows the select input only while idle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sel_q <= TMO_SHORT;
      else if (!run) sel_q <= tmo_sel_e'(sel);
   end

   assign limit = (sel_q == TMO_LONG) ? LIM_LONG : LIM_SHORT;
   assign hit   = tick & armed_q & (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                cnt_q <= '0;
      else if (!run)                             cnt_q <= '0;
      else if (tick && armed_q && cnt_q != limit) cnt_q <= cnt_q + 1'b1;
   end

   // One detection per high interval; re-armed once counting is held.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    armed_q <= 1'b1;
      else if (!run) armed_q <= 1'b1;
      else if (hit)  armed_q <= 1'b0;
   end

endmodule

// File: rtl/i2c_scl_timeout_mon.sv
module i2c_scl_timeout_mon
   import i2c_tmo_pkg::*;
#(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned PRESCALE     = 64,
   parameter int unsigned PERIOD_SHORT = 256,
   parameter int unsigned PERIOD_LONG  = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   input  logic tmo_en,
   input  logic tmo_sel,
   input  logic intf_en,
   input  logic intf_rst,
   input  logic tmo_flag_clr,
   input  logic irq_ack,
   output logic tmo_flag,
   output logic irq_req,
   output logic bus_busy
);

   localparam int unsigned LW = $bits(i2c_lines_t);

   i2c_lines_t raw_lines, sync_lines;
   logic       scl_s, sda_s;
   logic       clear_all;
   logic       bus_busy_q;
   logic       run;
   logic       hit;

   assign raw_lines.scl = scl_in;
   assign raw_lines.sda = sda_in;

   i2c_tmo_sync #(
      .STAGES  (SYNC_STAGES),
      .WIDTH   (LW),
      .RST_VAL ('1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_lines),
      .q     (sync_lines)
   );

   assign scl_s     = sync_lines.scl;
   assign sda_s     = sync_lines.sda;
   assign clear_all = intf_rst | ~intf_en;

   i2c_tmo_bus_state u_bus (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear_all),
      .scl   (scl_s),
      .sda   (sda_s),
      .busy  (bus_busy_q)
   );

   assign run = tmo_en & ~clear_all & bus_busy_q & scl_s;

   i2c_tmo_counter #(
      .PRESCALE     (PRESCALE),
      .PERIOD_SHORT (PERIOD_SHORT),
      .PERIOD_LONG  (PERIOD_LONG)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .sel   (tmo_sel),
      .hit   (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            tmo_flag <= 1'b0;
      else if (clear_all)    tmo_flag <= 1'b0;
      else if (hit)          tmo_flag <= 1'b1;
      else if (tmo_flag_clr) tmo_flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         irq_req <= 1'b0;
      else if (clear_all) irq_req <= 1'b0;
      else if (hit)       irq_req <= 1'b1;
      else if (irq_ack)   irq_req <= 1'b0;
   end

   assign bus_busy = bus_busy_q;

endmodule

// File: rtl/i2c_scl_timeout_chk.sv
module i2c_scl_timeout_chk (
   input logic clk,
   input logic rst_n,
   input logic tmo_en,
   input logic intf_en,
   input logic intf_rst,
   input logic tmo_flag_clr,
   input logic scl_s,
   input logic bus_busy,
   input logic tmo_flag,
   input logic irq_req
);

   AST_FLAG_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_flag) |-> irq_req); // R3

   AST_NO_FIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_flag) |-> $past(bus_busy)); // R6

   AST_NO_FIRE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_flag) |-> $past(tmo_en)); // R7

   AST_NO_FIRE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_flag) |-> $past(scl_s)); // R5

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_flag && !tmo_flag_clr && !intf_rst && intf_en) |=> tmo_flag); // R8

   AST_RECOVERY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (intf_rst || !intf_en) |=> (!tmo_flag && !irq_req && !bus_busy)); // R10

endmodule

bind i2c_scl_timeout_mon i2c_scl_timeout_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tmo_en       (tmo_en),
   .intf_en      (intf_en),
   .intf_rst     (intf_rst),
   .tmo_flag_clr (tmo_flag_clr),
   .scl_s        (scl_s),
   .bus_busy     (bus_busy_q),
   .tmo_flag     (tmo_flag),
   .irq_req      (irq_req)
);

// File: tb/i2c_scl_timeout_mon_test.sv
`timescale 1ns/1ps
module i2c_scl_timeout_mon_test;

   localparam int P  = 3;
   localparam int NS = 4;
   localparam int NL = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_in = 1'b1, sda_in = 1'b1;
   logic tmo_en = 1'b1, tmo_sel = 1'b0, intf_en = 1'b1, intf_rst = 1'b0;
   logic tmo_flag_clr = 1'b0, irq_ack = 1'b0;
   logic tmo_flag, irq_req, bus_busy;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   i2c_scl_timeout_mon #(
      .SYNC_STAGES (2),
      .PRESCALE    (P),
      .PERIOD_SHORT(NS),
      .PERIOD_LONG (NL)
   ) uut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .tmo_en(tmo_en), .tmo_sel(tmo_sel), .intf_en(intf_en), .intf_rst(intf_rst),
      .tmo_flag_clr(tmo_flag_clr), .irq_ack(irq_ack),
      .tmo_flag(tmo_flag), .irq_req(irq_req), .bus_busy(bus_busy)
   );

   function automatic int expect_edges(input int n);
      return 2 + (n + 1) * P;
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_start();
      scl_in = 1'b1; sda_in = 1'b1; idle(4);
      sda_in = 1'b0; idle(4);
      scl_in = 1'b0; idle(4);
   endtask

   // Raise SCL and count edges until the flag is seen; optionally flip select.
   task automatic measure(input int flip_at, output int edges);
      edges = 0;
      scl_in = 1'b1;
      for (int k = 1; k <= 400; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (k == flip_at) tmo_sel = ~tmo_sel;
         if (tmo_flag) begin
            edges = k;
            break;
         end
      end
   endtask

   task automatic clear_both();
      tmo_flag_clr = 1'b1; irq_ack = 1'b1; idle(1);
      tmo_flag_clr = 1'b0; irq_ack = 1'b0;
      scl_in = 1'b0; idle(4);
   endtask

   initial begin
      int n;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      idle(1);
      check("R1", "flag after reset", tmo_flag, 0);
      check("R1", "irq after reset", irq_req, 0);
      check("R1", "busy after reset", bus_busy, 0);

      idle(100);
      check("R6", "no timeout on idle bus", tmo_flag, 0);
      check("R2", "idle bus not busy", bus_busy, 0);

      do_start();
      check("R2", "busy after START", bus_busy, 1);

      for (int s = 0; s < 2; s++) begin
         tmo_sel = s[0];
         measure(0, n);
         check("R3", $sformatf("edges to timeout sel=%0d", s), n, expect_edges(s == 0 ? NS : NL));
         check("R3", "irq with flag", irq_req, 1);
         tmo_flag_clr = 1'b1; idle(1); tmo_flag_clr = 1'b0;
         check("R8", "flag cleared by software", tmo_flag, 0);
         check("R8", "irq kept after flag clear", irq_req, 1);
         idle(3 * expect_edges(NL));
         check("R9", "no refire while SCL high", tmo_flag, 0);
         irq_ack = 1'b1; idle(1); irq_ack = 1'b0;
         check("R8", "irq cleared by ack", irq_req, 0);
         scl_in = 1'b0; idle(4);
      end

      tmo_sel = 1'b0;
      measure(5, n);
      check("R4", "short limit held after select change", n, expect_edges(NS));
      clear_both();
      measure(5, n);
      check("R4", "long limit held after select change", n, expect_edges(NL));
      clear_both();
      tmo_sel = 1'b0;

      for (int k = 0; k < 4; k++) begin
         scl_in = 1'b1; idle(expect_edges(NS) - 4);
         scl_in = 1'b0; idle(4);
      end
      idle(4);
      check("R5", "short pulses never time out", tmo_flag, 0);

      tmo_en = 1'b0;
      scl_in = 1'b1; idle(3 * expect_edges(NL));
      check("R7", "no timeout when disabled", tmo_flag, 0);
      scl_in = 1'b0; idle(4);
      tmo_en = 1'b1;

      measure(0, n);
      check("R10", "timeout before reset strobe", n, expect_edges(NS));
      intf_rst = 1'b1; idle(1); intf_rst = 1'b0;
      check("R10", "flag cleared by reset strobe", tmo_flag, 0);
      check("R10", "irq cleared by reset strobe", irq_req, 0);
      check("R10", "busy cleared by reset strobe", bus_busy, 0);
      idle(3 * expect_edges(NL));
      check("R6", "no timeout after reset with SCL high", tmo_flag, 0);

      do_start();
      measure(0, n);
      check("R10", "timeout before disable", n, expect_edges(NS));
      intf_en = 1'b0; idle(2);
      check("R10", "flag cleared by disable", tmo_flag, 0);
      check("R10", "irq cleared by disable", irq_req, 0);
      check("R10", "busy cleared by disable", bus_busy, 0);
      intf_en = 1'b1; scl_in = 1'b0; idle(2);

      do_start();
      check("R2", "busy after second START", bus_busy, 1);
      scl_in = 1'b1; idle(3);
      sda_in = 1'b1; idle(4);
      check("R2", "idle after STOP", bus_busy, 0);
      idle(3 * expect_edges(NL));
      check("R6", "no timeout after STOP", tmo_flag, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule